// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches nine external interrupt pins and turns them into requests for an interrupt controller. One pin is a nonmaskable input. The other eight are maskable request lines, numbered 7 down to 0. Every pin first passes through a two-stage synchroniser.

Each maskable line has its own trigger condition: low level, falling edge, rising edge or both edges. When the trigger fires, the line's sticky status flag is set. Only a software write can clear that flag. A per-line enable gates the flag into a pending request. A 3-bit priority per line selects the winning pending request, and that winner is presented together with its line index and level.

The nonmaskable input fires on the edge chosen by a single polarity bit. It produces a one-cycle pulse that no enable or priority can hold back. Software reaches all settings and flags through a small register port. Writes are synchronous. Reads are combinational from the address.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset:
  - every register reads 0, which means low-level sense on all lines, all enables clear, all flags clear, all priorities 0 and falling-edge polarity for the nonmaskable input;
  - `irq_valid` is 0 and `nmi_req` is 0.
- R2: A pin change reaches detection through two register stages. A flag therefore reads 1 after the third rising clock edge following the pin change, and still reads 0 after the second.
- R3: The sense mode of line n is held at address 0, bits [2n+1:2n]. The encodings are 00 low level, 01 falling edge, 10 rising edge and 11 both edges. An edge that does not match the selected mode leaves the flag at 0.
- R4: The flag of line n reads at address 2, bit n, and stays set until cleared. Writing 0 to that bit clears it. Writing 1 to that bit has no effect.
- R5: The enable of line n is at address 1, bit n. A line whose enable is 0 still sets its flag but never makes `irq_valid` high.
- R6: The nonmaskable polarity is at address 5, bit 0, where 1 selects the rising edge and 0 the falling edge.
  - The selected edge gives a one-cycle `nmi_req` pulse, whatever the enables and priorities are.
  - The opposite edge gives no pulse.
- R7: In low-level mode the flag is set on every cycle the pin is low, so a clear issued while the pin is still low has no lasting effect. Once the pin is high, a clear leaves the flag at 0 and it does not set again.
- R8: The 3-bit priority of line n is at address 3 for lines 0 to 3 and at address 4 for lines 4 to 7. Within each word, line n occupies bits [4(n mod 4)+2 : 4(n mod 4)]. Among pending enabled lines, the one with the highest priority value wins.
- R9: When pending enabled lines share the highest priority value, the higher-numbered line wins.
- R10: When a trigger and a clear of the same flag fall in the same cycle, the flag ends up set.
- R11: `irq_valid` is 1 exactly when at least one line has both its flag and its enable set. While `irq_valid` is 1, `irq_index` and `irq_level` give the winning line and its priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Nonmaskable interrupt pin, asynchronous |
| irq_pins | input | 8 | Maskable request pins, bit n is line n, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| nmi_req | output | 1 | One-cycle nonmaskable request pulse |
| irq_valid | output | 1 | A maskable request is pending |
| irq_index | output | 3 | Line index of the winning request |
| irq_level | output | 3 | Priority of the winning request |

## Verification
The assertions check the following on every cycle:
- the arbiter never presents a disabled or unflagged line;
- no pending line outranks the presented winner;
- ties resolve toward the higher index;
- a flag never drops without a clear in the cycle before;
- a detected trigger always leaves its flag set on the next cycle, even against a clear.

Some behaviour can only be shown by the bench's scenarios, because it depends on the pin history:
- the exact three-edge detection latency;
- which edges each sense mode accepts and which it ignores;
- the level-mode re-assertion while the pin stays low;
- the direction and one-cycle width of the nonmaskable pulse.

// File: rtl/eis_pkg.sv
`timescale 1ns/1ps
package eis_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  localparam int A_MODE   = 0;
  localparam int A_ENABLE = 1;
  localparam int A_FLAGS  = 2;
  localparam int A_PRIO0  = 3;
  localparam int A_NMI    = 5;

  localparam int PRIO_SLOT = 4;

  // Trigger decision from the current and previous synchronised samples.
  function automatic logic sense_hit(sense_e mode, logic cur, logic prev);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (mode)
      SENSE_LOW:  sense_hit = ~cur;
      SENSE_FALL: sense_hit = fall;
      SENSE_RISE: sense_hit = rise;
      default:    sense_hit = rise | fall;
    endcase
  endfunction

  // Register word that holds the priority of a given line.
  function automatic int prio_word(int line, int lines_per_word);
    prio_word = A_PRIO0 + line / lines_per_word;
  endfunction

  // Bit offset of a line's priority inside its word.
  function automatic int prio_offset(int line, int lines_per_word);
    prio_offset = (line % lines_per_word) * PRIO_SLOT;
  endfunction

endpackage

// File: rtl/eis_sync.sv
`timescale 1ns/1ps
module eis_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2,
  parameter bit RST_HI = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage[s] <= {W{RST_HI}};
        end else begin
          if (s == 0) stage[s] <= d;
          else        stage[s] <= stage[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/eis_line.sv
`timescale 1ns/1ps
module eis_line
  import eis_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   samp,
  input  sense_e mode,
  input  logic   clr,
  output logic   hit,
  output logic   flag
);
  logic prev_q;
  logic flag_q;

  assign hit = sense_hit(mode, samp, prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= samp;
      flag_q <= hit | (flag_q & ~clr);
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/eis_nmi.sv
`timescale 1ns/1ps
module eis_nmi
  import eis_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic samp,
  input  logic rise_sel,
  output logic pulse
);
  logic   prev_q;
  logic   pulse_q;
  sense_e edge_mode;
  logic   nmi_hit;

  assign edge_mode = rise_sel ? SENSE_RISE : SENSE_FALL;
  assign nmi_hit   = sense_hit(edge_mode, samp, prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= samp;
      pulse_q <= nmi_hit;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/eis_arb.sv
`timescale 1ns/1ps
module eis_arb #(
  parameter int N  = 8,
  parameter int PW = 3,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]    pend,
  input  logic [N*PW-1:0] prio,
  output logic            valid,
  output logic [IW-1:0]   idx,
  output logic [PW-1:0]   lvl
);
  // Ascending scan with >=: an equal level later in the scan takes over,
  // so ties go to the higher index.
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    lvl   = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && (!valid || prio[i*PW +: PW] >= lvl)) begin
        valid = 1'b1;
        idx   = IW'(i);
        lvl   = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/ext_irq_sense.sv
`timescale 1ns/1ps
module ext_irq_sense
  import eis_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int PRIO_W = 3,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      nmi_pin,
  input  logic [NLINES-1:0]         irq_pins,
  input  logic                      reg_wr,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  output logic                      nmi_req,
  output logic                      irq_valid,
  output logic [$clog2(NLINES)-1:0] irq_index,
  output logic [PRIO_W-1:0]         irq_level
);
  localparam int LPW   = DATA_W / PRIO_SLOT;
  localparam int MODEW = 2 * NLINES;

  // Configuration state
  logic [MODEW-1:0]  mode_q;
  logic [NLINES-1:0] en_q;
  logic [PRIO_W-1:0] prio_q [NLINES];
  logic              nmi_rise_q;

  // Named internal events
  logic [NLINES-1:0]        samp_w;
  logic                     nmi_samp_w;
  logic [NLINES-1:0]        hit_w;
  logic [NLINES-1:0]        flag_w;
  logic [NLINES-1:0]        clr_w;
  logic [NLINES-1:0]        pend_w;
  logic [NLINES*PRIO_W-1:0] prio_flat;
  logic                     wr_mode, wr_en, wr_flags, wr_nmi;

  assign wr_mode  = reg_wr && (reg_addr == ADDR_W'(A_MODE));
  assign wr_en    = reg_wr && (reg_addr == ADDR_W'(A_ENABLE));
  assign wr_flags = reg_wr && (reg_addr == ADDR_W'(A_FLAGS));
  assign wr_nmi   = reg_wr && (reg_addr == ADDR_W'(A_NMI));

  // Synchroniser for all pins
  eis_sync #(.W(NLINES + 1), .STAGES(2), .RST_HI(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({nmi_pin, irq_pins}),
    .q     ({nmi_samp_w, samp_w})
  );

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      en_q       <= '0;
      nmi_rise_q <= 1'b0;
    end else begin
      if (wr_mode) mode_q     <= reg_wdata[MODEW-1:0];
      if (wr_en)   en_q       <= reg_wdata[NLINES-1:0];
      if (wr_nmi)  nmi_rise_q <= reg_wdata[0];
    end
  end

  // Per-line detection, flag, priority storage
  generate
    for (genvar i = 0; i < NLINES; i++) begin : g_line
      localparam int WORD = prio_word(i, LPW);
      localparam int OFS  = prio_offset(i, LPW);

      // Write 0 to a flag bit clears it; 1 leaves it alone
      assign clr_w[i] = wr_flags && !reg_wdata[i];

      eis_line u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .samp  (samp_w[i]),
        .mode  (sense_e'(mode_q[2*i +: 2])),
        .clr   (clr_w[i]),
        .hit   (hit_w[i]),
        .flag  (flag_w[i])
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prio_q[i] <= '0;
        end else if (reg_wr && reg_addr == ADDR_W'(WORD)) begin
          prio_q[i] <= reg_wdata[OFS +: PRIO_W];
        end
      end

      assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
    end
  endgenerate

  assign pend_w = flag_w & en_q;

  eis_arb #(.N(NLINES), .PW(PRIO_W)) u_arb (
    .pend  (pend_w),
    .prio  (prio_flat),
    .valid (irq_valid),
    .idx   (irq_index),
    .lvl   (irq_level)
  );

  eis_nmi u_nmi (
    .clk      (clk),
    .rst_n    (rst_n),
    .samp     (nmi_samp_w),
    .rise_sel (nmi_rise_q),
    .pulse    (nmi_req)
  );

  // Read mux
  always_comb begin
    reg_rdata = '0;
    case (int'(reg_addr))
      A_MODE:   reg_rdata[MODEW-1:0]  = mode_q;
      A_ENABLE: reg_rdata[NLINES-1:0] = en_q;
      A_FLAGS:  reg_rdata[NLINES-1:0] = flag_w;
      A_NMI:    reg_rdata[0]          = nmi_rise_q;
      default: begin
        for (int i = 0; i < NLINES; i++) begin
          if (int'(reg_addr) == prio_word(i, LPW))
            reg_rdata[prio_offset(i, LPW) +: PRIO_W] = prio_q[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/eis_chk.sv
`timescale 1ns/1ps
module eis_chk #(
  parameter int N  = 8,
  parameter int PW = 3,
  parameter int IW = $clog2(N)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    flags,
  input logic [N-1:0]    en,
  input logic [N*PW-1:0] prio,
  input logic [N-1:0]    clr,
  input logic [N-1:0]    hit,
  input logic            irq_valid,
  input logic [IW-1:0]   irq_index,
  input logic [PW-1:0]   irq_level
);
  // R5 / R11: the presented winner is flagged and enabled
  a_r5_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (en[irq_index] && flags[irq_index]));

  // R11: nothing pending means no request
  a_r11_idle_when_none: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & en) == '0) |-> !irq_valid);

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      localparam logic [IW-1:0] IDX = IW'(i);

      // R8: no pending line outranks the winner
      a_r8_no_higher_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && flags[i] && en[i]) |-> (prio[i*PW +: PW] <= irq_level));

      // R9: ties go to the higher index
      a_r9_tie_high_index: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && flags[i] && en[i] && prio[i*PW +: PW] == irq_level)
          |-> (IDX <= irq_index));

      // R4: a flag holds while not cleared
      a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[i] && !clr[i]) |=> flags[i]);

      // R10: a trigger always leaves the flag set, clear or not
      a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hit[i] |=> flags[i]);

      // R7: a flag only drops after a clear
      a_r7_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[i]) |-> $past(clr[i]));
    end
  endgenerate
endmodule

bind ext_irq_sense eis_chk #(.N(NLINES), .PW(PRIO_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flags     (flag_w),
  .en        (en_q),
  .prio      (prio_flat),
  .clr       (clr_w),
  .hit       (hit_w),
  .irq_valid (irq_valid),
  .irq_index (irq_index),
  .irq_level (irq_level)
);

// File: tb/sim_ext_irq_sense.sv
`timescale 1ns/1ps
module sim_ext_irq_sense;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_pin = 1'b1;
  logic [7:0]  irq_pins = 8'hFF;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        nmi_req;
  logic        irq_valid;
  logic [2:0]  irq_index;
  logic [2:0]  irq_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam int S_RD = 0, S_VALID = 1, S_INDEX = 2, S_LEVEL = 3, S_NMI = 4;

  string       q_req[$];
  int          q_sel[$];
  logic [15:0] q_exp[$];

  always #2 clk = ~clk;

  ext_irq_sense u0 (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .irq_pins(irq_pins),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .nmi_req(nmi_req), .irq_valid(irq_valid),
    .irq_index(irq_index), .irq_level(irq_level)
  );

  function automatic logic [15:0] observe(int sel);
    case (sel)
      S_RD:    return reg_rdata;
      S_VALID: return {15'd0, irq_valid};
      S_INDEX: return {13'd0, irq_index};
      S_LEVEL: return {13'd0, irq_level};
      default: return {15'd0, nmi_req};
    endcase
  endfunction

  // Monitor: compares queued expectations half a nanosecond after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #0.5;
      while (q_sel.size() > 0) begin
        string       r;
        int          s;
        logic [15:0] e;
        logic [15:0] a;
        r = q_req.pop_front();
        s = q_sel.pop_front();
        e = q_exp.pop_front();
        a = observe(s);
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", r, s, a, e);
        end
      end
    end
  end

  // Driver helpers
  task automatic expect_item(string req, int sel, logic [15:0] exp);
    q_req.push_back(req);
    q_sel.push_back(sel);
    q_exp.push_back(exp);
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdchk(logic [2:0] a, string req, logic [15:0] exp);
    reg_addr = a;
    expect_item(req, S_RD, exp);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rdchk(3'(a), "R1 reset register", 16'h0);
      if (a == 0) begin
        expect_item("R1 reset valid", S_VALID, 16'h0);
        expect_item("R1 reset nmi", S_NMI, 16'h0);
      end
      cyc(1);
    end

    // R3: line0 falling, line1 rising, line2 both
    wr(3'd0, 16'h0039);
    rdchk(3'd0, "R3 mode readback", 16'h0039);
    wr(3'd1, 16'h0007);

    // R2: three-edge latency on line0
    cyc(1);
    irq_pins[0] = 1'b0;
    cyc(2);
    rdchk(3'd2, "R2 flag not yet set", 16'h0000);
    cyc(1);
    rdchk(3'd2, "R2 R3 falling flag set", 16'h0001);
    expect_item("R11 valid with one pending", S_VALID, 16'h1);
    expect_item("R11 index line0", S_INDEX, 16'h0);

    // R4: write 1 no effect, write 0 clears
    wr(3'd2, 16'hFFFF);
    rdchk(3'd2, "R4 write one keeps flag", 16'h0001);
    wr(3'd2, 16'hFFFE);
    rdchk(3'd2, "R4 write zero clears", 16'h0000);

    // R3: rising mode ignores fall, takes rise
    cyc(1); irq_pins[1] = 1'b0; cyc(3);
    rdchk(3'd2, "R3 rising ignores fall", 16'h0000);
    cyc(1); irq_pins[1] = 1'b1; cyc(3);
    rdchk(3'd2, "R3 rising edge sets", 16'h0002);

    // R3: both edges
    cyc(1); irq_pins[2] = 1'b0; cyc(3);
    rdchk(3'd2, "R3 both mode fall", 16'h0006);
    wr(3'd2, 16'hFFFB);
    rdchk(3'd2, "R4 clear only bit2", 16'h0002);
    cyc(1); irq_pins[2] = 1'b1; cyc(3);
    rdchk(3'd2, "R3 both mode rise", 16'h0006);

    // R8: line1 level 5 beats line2 level 3
    wr(3'd3, 16'h0350);
    rdchk(3'd3, "R8 prio readback", 16'h0350);
    expect_item("R8 winner index", S_INDEX, 16'h1);
    expect_item("R8 winner level", S_LEVEL, 16'h5);

    // R9: tie at 5 goes to line2
    wr(3'd3, 16'h0550);
    expect_item("R9 tie index", S_INDEX, 16'h2);
    expect_item("R9 tie level", S_LEVEL, 16'h5);

    // R11: all cleared -> no request
    wr(3'd2, 16'h0000);
    expect_item("R11 none pending", S_VALID, 16'h0);

    // R5: disabled low-level line sets flag, no request
    cyc(1); irq_pins[3] = 1'b0; cyc(3);
    rdchk(3'd2, "R5 flag set while disabled", 16'h0008);
    expect_item("R5 no request when disabled", S_VALID, 16'h0);
    wr(3'd1, 16'h000F);
    expect_item("R11 enabled line requests", S_VALID, 16'h1);
    expect_item("R11 index line3", S_INDEX, 16'h3);

    // R7: clear while low does not stick; after release it does
    wr(3'd2, 16'hFFF7);
    rdchk(3'd2, "R7 clear while low reasserts", 16'h0008);
    cyc(1); irq_pins[3] = 1'b1; cyc(3);
    wr(3'd2, 16'hFFF7);
    cyc(3);
    rdchk(3'd2, "R7 cleared after release", 16'h0000);
    expect_item("R7 no request after clear", S_VALID, 16'h0);

    // R10: line4 falling; trigger and clear in the same cycle
    wr(3'd0, 16'h0139);
    wr(3'd1, 16'h001F);
    cyc(1);
    irq_pins[4] = 1'b0;
    cyc(2);
    reg_addr  = 3'd2;
    reg_wdata = 16'h0000;
    reg_wr    = 1'b1;
    cyc(1);
    reg_wr = 1'b0;
    rdchk(3'd2, "R10 set wins over clear", 16'h0010);
    expect_item("R10 request index", S_INDEX, 16'h4);

    // R8: upper priority word, line4 bits 2:0
    wr(3'd4, 16'h0006);
    expect_item("R8 upper word level", S_LEVEL, 16'h6);

    // R6: nmi falling edge default
    cyc(1); nmi_pin = 1'b0; cyc(2);
    expect_item("R6 nmi not yet", S_NMI, 16'h0);
    cyc(1);
    expect_item("R6 nmi pulse falling", S_NMI, 16'h1);
    cyc(1);
    expect_item("R6 nmi pulse one cycle", S_NMI, 16'h0);

    // R6: rising polarity
    wr(3'd5, 16'h0001);
    nmi_pin = 1'b1;
    cyc(3);
    expect_item("R6 nmi pulse rising", S_NMI, 16'h1);
    cyc(1); nmi_pin = 1'b0; cyc(3);
    expect_item("R6 rising ignores fall", S_NMI, 16'h0);
    cyc(1);
    rdchk(3'd5, "R6 polarity readback", 16'h0001);

    cyc(2);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Watchdog
  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule